// File: doc/BRIEF.md
# Shuffled Gaussian Noise Polynomial Buffer

This block gathers a full polynomial of discrete Gaussian noise coefficients into a single-port RAM. A sampler delivers the coefficients one at a time, and each one carries a flag that tells whether it came from the fast table path or the slow, variable-time tree walk. Fast coefficients fill the RAM upward from address 0. Slow coefficients fill it downward from the top address. Once every slot is full, the slow coefficients therefore sit in one contiguous block at the top of the RAM.

A shuffle pass then removes the positional hint that this placement leaves behind. Starting at the lowest slot of the slow block and moving upward, each slow coefficient is exchanged with a position below it. That position comes from an external random index stream. Any index that is not strictly below the current slot is thrown away and the next one is taken. When no slow coefficients remain, the block raises `done`. The RAM can then be read through a registered read port. Sampler pulses have no effect from the end of filling until `start` begins a new polynomial.

Top module: `gauss_shuffle_buf`

## Requirements
- R1: After reset the block is filling, `done` is low and `idx_take` is low.
- R2: While filling, the k-th accepted sample with `smp_fast`=1 (k counted from 0) is written at address k.
- R3: While filling, the k-th accepted sample with `smp_fast`=0 (k counted from 0) is written at address N-1-k.
- R4: Filling ends with the N-th accepted sample. `done` stays low until then, and the fill count never exceeds N.
- R5: In the shuffle, with s slow samples still to process, the current slot is p = N-s. An index with value >= p is consumed through `idx_take` and changes nothing. The number of indices consumed equals the number a reference model draws.
- R6: An accepted index j < p exchanges the contents of addresses j and p through the sequence read j, read p, write j, write p (4 cycles). After the exchange, p moves up by one.
- R7: When every sample was slow, the slot p = 0 draws no index and stays in place.
- R8: `done` rises only when no slow sample remains. The final RAM holds the same multiset of values as the accepted samples.
- R9: Sampler pulses after the N-th sample, during the shuffle or after `done`, change neither the RAM nor the counters.
- R10: `start` drops `done` on the next cycle, clears both counters and begins a new fill.
- R11: While `done` is high, `rd_data` shows the word at `rd_addr` from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart collection of a new polynomial |
| smp_valid | input | 1 | One-cycle pulse, sample present |
| smp_fast | input | 1 | 1: sample came from the table path; 0: from the tree walk |
| smp_data | input | DW | Sample value |
| idx_valid | input | 1 | Random index present |
| idx_data | input | $clog2(N) | Random index |
| idx_take | output | 1 | Index consumed this cycle |
| done | output | 1 | Polynomial ready and shuffled |
| rd_addr | input | $clog2(N) | Read address, used while done |
| rd_data | output | DW | Read data, one cycle after rd_addr |

## Verification
The bound checker checks properties on every cycle. It checks that the fill count stays within N and that a fast sample steps the lower counter by exactly one. It checks that a rejected index leaves the block drawing again and that an accepted index enters the four-step exchange. It also checks that nothing is written and no slow sample is pending while `done` is high. The bench scenarios are needed for what these properties cannot show: the final placement of every coefficient after the scripted exchanges, preservation of the value multiset, and the exact count of indices consumed. They also cover the all-fast, all-slow and restart-mid-fill cases.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
   typedef enum logic [2:0] {
      ST_FILL,
      ST_DRAW,
      ST_RD_J,
      ST_RD_P,
      ST_WR_J,
      ST_WR_P,
      ST_DONE
   } gsb_state_t;
endpackage

// File: rtl/gsb_ram.sv
module gsb_ram #(
   parameter int DW    = 8,
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
   end
endmodule

// File: rtl/gsb_place.sv
module gsb_place #(
   parameter int N  = 256,
   parameter int AW = 8,
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          inc_fast,
   input  logic          inc_slow,
   input  logic          dec_slow,
   output logic [CW-1:0] c_fast,
   output logic [CW-1:0] c_slow,
   output logic [CW-1:0] slot,
   output logic [AW-1:0] slow_wr_addr,
   output logic          fill_last,
   output logic          slow_last
);
   localparam logic [CW-1:0] NV   = CW'(N);
   localparam logic [CW-1:0] NM1  = CW'(N - 1);
   localparam bit            POW2 = (N == (1 << AW));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_fast <= '0;
         c_slow <= '0;
      end else if (clear) begin
         c_fast <= '0;
         c_slow <= '0;
      end else begin
         if (inc_fast) c_fast <= c_fast + 1'b1;
         if (inc_slow) c_slow <= c_slow + 1'b1;
         else if (dec_slow) c_slow <= c_slow - 1'b1;
      end
   end

   assign slot      = NV - c_slow;
   assign fill_last = ((c_fast + c_slow) == NM1);
   assign slow_last = (c_slow == CW'(1));

   generate
      if (POW2) begin : g_inv_addr
         assign slow_wr_addr = ~c_slow[AW-1:0];
      end else begin : g_sub_addr
         logic [CW-1:0] diff;
         assign diff         = NM1 - c_slow;
         assign slow_wr_addr = diff[AW-1:0];
      end
   endgenerate
endmodule

// File: rtl/gauss_shuffle_buf.sv
module gauss_shuffle_buf #(
   parameter int N  = 256,
   parameter int DW = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 smp_valid,
   input  logic                 smp_fast,
   input  logic [DW-1:0]        smp_data,
   input  logic                 idx_valid,
   input  logic [$clog2(N)-1:0] idx_data,
   output logic                 idx_take,
   output logic                 done,
   input  logic [$clog2(N)-1:0] rd_addr,
   output logic [DW-1:0]        rd_data
);
   import gsb_pkg::*;

   localparam int AW = $clog2(N);
   localparam int CW = AW + 1;
   localparam int IW = AW;

   generate
      if (N < 2) begin : g_bad_n
         $error("N must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be at least 1");
      end
   endgenerate

   gsb_state_t    state, state_nx;
   logic [CW-1:0] c1, c2, slot;
   logic [AW-1:0] slow_wr_addr;
   logic          fill_last, slow_last;
   logic          take_smp, accept, slot_zero, dec_slow;
   logic [AW-1:0] j_q;
   logic [DW-1:0] hold_q, ram_q, wdata;
   logic [AW-1:0] addr;
   logic          we;

   assign take_smp  = (state == ST_FILL) && smp_valid;
   assign slot_zero = (slot == '0);
   assign idx_take  = (state == ST_DRAW) && idx_valid && !slot_zero;
   assign accept    = idx_take && ({1'b0, idx_data} < slot);
   assign dec_slow  = ((state == ST_DRAW) && slot_zero) || (state == ST_WR_P);

   gsb_place #(.N(N), .AW(AW), .CW(CW)) u_place (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (start),
      .inc_fast    (take_smp && smp_fast),
      .inc_slow    (take_smp && !smp_fast),
      .dec_slow    (dec_slow),
      .c_fast      (c1),
      .c_slow      (c2),
      .slot        (slot),
      .slow_wr_addr(slow_wr_addr),
      .fill_last   (fill_last),
      .slow_last   (slow_last)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_FILL: if (take_smp && fill_last)
                     state_nx = ((c2 != '0) || !smp_fast) ? ST_DRAW : ST_DONE;
         ST_DRAW: if (slot_zero)  state_nx = slow_last ? ST_DONE : ST_DRAW;
                  else if (accept) state_nx = ST_RD_J;
         ST_RD_J: state_nx = ST_RD_P;
         ST_RD_P: state_nx = ST_WR_J;
         ST_WR_J: state_nx = ST_WR_P;
         ST_WR_P: state_nx = slow_last ? ST_DONE : ST_DRAW;
         ST_DONE: state_nx = ST_DONE;
         default: state_nx = ST_FILL;
      endcase
      if (start) state_nx = ST_FILL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_FILL;
         j_q    <= '0;
         hold_q <= '0;
      end else begin
         state <= state_nx;
         if (accept)            j_q    <= idx_data;
         if (state == ST_RD_P)  hold_q <= ram_q;
      end
   end

   always_comb begin
      addr  = rd_addr;
      wdata = smp_data;
      we    = 1'b0;
      unique case (state)
         ST_FILL: begin
            addr = smp_fast ? c1[AW-1:0] : slow_wr_addr;
            we   = take_smp;
         end
         ST_RD_J: addr = j_q;
         ST_RD_P: addr = slot[AW-1:0];
         ST_WR_J: begin addr = j_q;          wdata = ram_q;  we = 1'b1; end
         ST_WR_P: begin addr = slot[AW-1:0]; wdata = hold_q; we = 1'b1; end
         default: addr = rd_addr;
      endcase
   end

   gsb_ram #(.DW(DW), .DEPTH(N), .AW(AW)) u_ram (
      .clk  (clk),
      .we   (we),
      .addr (addr),
      .wdata(wdata),
      .rdata(ram_q)
   );

   assign done    = (state == ST_DONE);
   assign rd_data = ram_q;
endmodule

// File: rtl/gsb_chk.sv
module gsb_chk #(
   parameter int N  = 256,
   parameter int CW = 9,
   parameter int IW = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input gsb_pkg::gsb_state_t state,
   input logic [CW-1:0]       c1,
   input logic [CW-1:0]       c2,
   input logic                smp_valid,
   input logic                smp_fast,
   input logic                idx_take,
   input logic                accept,
   input logic                we,
   input logic                done
);
   import gsb_pkg::*;

   a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, c1} + {1'b0, c2}) <= (CW + 1)'(N));

   a_r2_fast_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL && smp_valid && smp_fast && !start) |=> (c1 == $past(c1) + 1'b1));

   a_r5_reject_redraw: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_take && !accept && !start) |=> (state == ST_DRAW));

   a_r6_accept_exchange: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !start) |=> (state == ST_RD_J));

   a_r6_exchange_order: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_P && !start) |=> (state == ST_WR_J));

   a_r8_done_drained: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (c2 == '0));

   a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !we);

   a_r10_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done && c1 == '0 && c2 == '0));
endmodule

bind gauss_shuffle_buf gsb_chk #(.N(N), .CW(CW), .IW(IW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .state    (state),
   .c1       (c1),
   .c2       (c2),
   .smp_valid(smp_valid),
   .smp_fast (smp_fast),
   .idx_take (idx_take),
   .accept   (accept),
   .we       (we),
   .done     (done)
);

// File: tb/gauss_shuffle_buf_bench.sv
`timescale 1ns/1ps
module gauss_shuffle_buf_bench;
   localparam int N   = 256;
   localparam int DW  = 8;
   localparam int AW  = $clog2(N);
   localparam int SCR = 8192;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic smp_valid = 1'b0, smp_fast = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic idx_valid = 1'b0;
   logic [AW-1:0] idx_data = '0;
   logic idx_take, done;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;

   always #2 clk = ~clk;

   gauss_shuffle_buf #(.N(N), .DW(DW)) u_gauss_shuffle_buf (
      .clk(clk), .rst_n(rst_n), .start(start),
      .smp_valid(smp_valid), .smp_fast(smp_fast), .smp_data(smp_data),
      .idx_valid(idx_valid), .idx_data(idx_data), .idx_take(idx_take),
      .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   int nchk = 0, nfail = 0, cyc = 0;
   int script [SCR];
   int ip = 0;
   int sv [N];
   bit sf [N];
   int exp_mem [N];
   int exp_used;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   // index source: one scripted value offered per cycle, advanced when consumed
   initial begin
      bit tk;
      wait (rst_n);
      forever begin
         @(negedge clk);
         idx_valid = 1'b1;
         idx_data  = AW'(script[ip % SCR]);
         #1 tk = idx_take;
         @(posedge clk);
         if (tk) ip++;
      end
   end

   // reference model: placement, then exchanges driven by the script from base
   function automatic void model(input int base);
      int lo = 0, s = 0, k = base, p, j, t;
      for (int i = 0; i < N; i++) begin
         if (sf[i]) begin exp_mem[lo] = sv[i]; lo++; end
         else       begin exp_mem[N-1-s] = sv[i]; s++; end
      end
      while (s > 0) begin
         p = N - s;
         if (p != 0) begin
            do begin j = script[k % SCR]; k++; end while (j >= p);
            t = exp_mem[j]; exp_mem[j] = exp_mem[p]; exp_mem[p] = t;
         end
         s--;
      end
      exp_used = k - base;
   endfunction

   task automatic send(input int v, input bit f);
      @(negedge clk);
      smp_valid = 1'b1; smp_data = DW'(v); smp_fast = f;
      @(posedge clk); #1;
      smp_valid = 1'b0;
   endtask

   task automatic readback(input string req);
      int hist_e [256];
      int hist_a [256];
      int got [N];
      bit same = 1'b1;
      for (int v = 0; v < 256; v++) begin hist_e[v] = 0; hist_a[v] = 0; end
      for (int a = 0; a < N; a++) begin
         @(negedge clk); rd_addr = AW'(a);
         @(negedge clk); got[a] = int'(rd_data);
         check(got[a] == exp_mem[a], req, got[a], exp_mem[a]);
      end
      for (int i = 0; i < N; i++) begin hist_e[sv[i]]++; hist_a[got[i]]++; end
      for (int v = 0; v < 256; v++) if (hist_e[v] != hist_a[v]) same = 1'b0;
      check(same, "R8 multiset", int'(same), 1);
   endtask

   task automatic scenario(input int slow_pct, input bit junk, input string req);
      int base, guard;
      for (int i = 0; i < N; i++) begin
         sv[i] = int'($urandom % 256);
         sf[i] = (int'($urandom % 100) >= slow_pct);
      end
      base = ip;
      model(base);
      for (int i = 0; i < N; i++) begin
         send(sv[i], sf[i]);
         if (i == N - 2) check(done == 1'b0, "R4 early done", int'(done), 0);
      end
      guard = 0;
      while (!done && guard < 20000) begin
         if (junk) send(int'($urandom % 256), $urandom % 2);
         else @(negedge clk);
         guard++;
      end
      @(negedge clk);
      check(done == 1'b1, "R8 done", int'(done), 1);
      check((ip - base) == exp_used, "R5 indices consumed", ip - base, exp_used);
      for (int i = 0; i < 4; i++) send(int'($urandom % 256), $urandom % 2);  // R9
      readback(req);
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(done == 1'b0, "R10 done cleared", int'(done), 0);
   endtask

   initial begin
      void'($urandom(32'd20240917));
      for (int i = 0; i < SCR; i++)
         script[i] = ($urandom % 4 == 0) ? (N - 1 - int'($urandom % 8)) : int'($urandom % N);
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R1 reset done", int'(done), 0);
      check(idx_take == 1'b0, "R1 reset idx_take", int'(idx_take), 0);
      rst_n = 1'b1;

      // mixed origins, junk pulses during shuffle: R2 R3 R6 R9 R11
      scenario(8, 1'b1, "R6 mixed layout");
      pulse_start();
      // all fast: no shuffle, identity layout R2
      scenario(0, 1'b0, "R2 all fast layout");
      pulse_start();
      // heavy slow share: R3 R5 R6
      scenario(50, 1'b1, "R3 heavy slow layout");
      pulse_start();
      // all slow: slot 0 draws nothing R7
      scenario(100, 1'b0, "R7 all slow layout");
      pulse_start();
      // restart in the middle of filling R10
      for (int i = 0; i < 100; i++) send(int'($urandom % 256), $urandom % 2);
      pulse_start();
      scenario(20, 1'b0, "R10 after restart layout");

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule